// File: doc/BRIEF.md
# Four-Quadrant PWM Mode Steering

This block produces the switching pulses for a bidirectional flyback converter that generates a ringing waveform. It steers those pulses to one of three gate-drive logic outputs: the primary switch, a p-channel secondary switch and an n-channel secondary switch. A digital triangular ramp runs up and down continuously. A pulse starts on the falling half of the ramp once the ramp drops below the error-magnitude code, and it lasts until the ramp reaches its bottom. This limits the duty cycle to just under one half.

The operating mode is taken from the sign of the reference and the sign of the error. The mode is latched once per ramp period, at the ramp peak. It decides which gate carries the pulse and which secondary gate, if any, acts as a synchronous rectifier during the following rising half. Enable low turns every gate off. A DC current-limit flag prevents a new pulse from starting for the rest of the current ramp period. A range-good flag reports whether the magnitude code commands a usable duty cycle.

Top module: `qsteer_top`

## Requirements
- R1: While reset is held, gd1_o=0, gd2_n_o=1, gd3_o=0 and rgood_o=0. After release the ramp starts at 0 and rises by one per clock to 2^MAG_W-1, then falls by one per clock back to 0, so one period is 2^(MAG_W+1) clocks. Every output shows, one clock later, the ramp position and the inputs sampled at that position.
- R2: The mode is {ref_neg_i, err_neg_i}. 00 is mode 1, 01 is mode 2, 11 is mode 3 and 10 is mode 4. It is sampled only at the ramp peak (the last rising position) and holds until the next peak. Its reset value is mode 2.
- R3: In mode 1 the pulse appears on gd1_o, and gd2 is the rectifier.
- R4: In mode 2 the pulse appears on gd3_o, and no gate rectifies.
- R5: In mode 3 the pulse appears on gd1_o, and gd3 is the rectifier.
- R6: In mode 4 the pulse appears on gd2, and no gate rectifies.
- R7: A pulse starts at the first falling position where the ramp value is below mag_i. It stays on until the last falling position, so it is mag_i clocks wide. A mag_i of 0 gives no pulse.
- R8: The rectifier selected by the mode latched at the previous peak is on during every rising position except the first. The pulse gate and a rectifier are never on together. At least one clock with every gate off separates them.
- R9: gd2 is active low on gd2_n_o (0 = switch on). gd1_o and gd3_o are active high.
- R10: A clock sampled with en_i low turns every gate off at the next output update.
- R11: A current-limit flag sampled at a ramp position at or before the pulse start blocks the pulse for the rest of that ramp period. A flag sampled after the pulse has started does not shorten it. The next period is not affected.
- R12: rgood_o is 1 when the sampled mag_i lies strictly between 0 and 2^MAG_W-1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Gate enable |
| ref_neg_i | input | 1 | Reference sign, 1 = negative |
| err_neg_i | input | 1 | Error sign |
| mag_i | input | MAG_W | Error-magnitude code |
| ilim_i | input | 1 | DC current-limit flag |
| gd1_o | output | 1 | Primary gate, active high |
| gd2_n_o | output | 1 | P-channel secondary gate, active low |
| gd3_o | output | 1 | N-channel secondary gate, active high |
| rgood_o | output | 1 | Magnitude within usable range |

## Verification
The current-limit flag and the pulse turn-on can land on the same ramp position. The bench provokes this by raising the flag once before the start position, once exactly at it and once after it, in three consecutive periods with the same magnitude. It also drops enable in the middle of a pulse. A scoreboard model built from the timing rules predicts every output on every clock. The test passes only if the pulse is absent in the first two periods and runs to full width in the third.

// File: rtl/qsteer_pkg.sv
package qsteer_pkg;

    // Mode code equals {reference negative, error sign}
    typedef enum logic [1:0] {
        MODE_FWD_POS = 2'b00,
        MODE_REV_POS = 2'b01,
        MODE_REV_NEG = 2'b10,
        MODE_FWD_NEG = 2'b11
    } qmode_e;

    function automatic qmode_e decode_mode(input logic ref_neg, input logic err_neg);
        qmode_e m;
        case ({ref_neg, err_neg})
            2'b00:   m = MODE_FWD_POS;
            2'b01:   m = MODE_REV_POS;
            2'b11:   m = MODE_FWD_NEG;
            default: m = MODE_REV_NEG;
        endcase
        return m;
    endfunction

    // Gate that carries the pulse in a given mode: [0]=primary, [1]=p-side, [2]=n-side
    function automatic logic [2:0] pulse_gate(input qmode_e m);
        logic [2:0] g;
        case (m)
            MODE_FWD_POS, MODE_FWD_NEG: g = 3'b001;
            MODE_REV_POS:               g = 3'b100;
            default:                    g = 3'b010;
        endcase
        return g;
    endfunction

    // Gate that rectifies in a given mode (same bit order)
    function automatic logic [2:0] rect_gate(input qmode_e m);
        logic [2:0] g;
        case (m)
            MODE_FWD_POS: g = 3'b010;
            MODE_FWD_NEG: g = 3'b100;
            default:      g = 3'b000;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/qsteer_ramp.sv
module qsteer_ramp #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic [W-1:0] cnt_o,
    output logic         falling_o,
    output logic         peak_o,
    output logic         wrap_o,
    output logic         rise_body_o
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } ramp_s;

    ramp_s ramp_d, ramp_q;

    always_comb begin
        ramp_d = ramp_q;
        if (!ramp_q.down) begin
            if (ramp_q.cnt == TOP) ramp_d.down = 1'b1;
            else                   ramp_d.cnt  = ramp_q.cnt + 1'b1;
        end else begin
            if (ramp_q.cnt == '0)  ramp_d.down = 1'b0;
            else                   ramp_d.cnt  = ramp_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ramp_q <= '0;
        else         ramp_q <= ramp_d;
    end

    assign cnt_o       = ramp_q.cnt;
    assign falling_o   = ramp_q.down;
    assign peak_o      = !ramp_q.down && (ramp_q.cnt == TOP);
    assign wrap_o      = ramp_q.down && (ramp_q.cnt == '0);
    assign rise_body_o = !ramp_q.down && (ramp_q.cnt != '0);

endmodule

// File: rtl/qsteer_pwm.sv
module qsteer_pwm #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         ilim_i,
    input  logic [W-1:0] mag_i,
    input  logic [W-1:0] cnt_i,
    input  logic         falling_i,
    input  logic         wrap_i,
    output logic         pwm_o
);
    typedef struct packed {
        logic pwm;
        logic blk;
    } pwm_s;

    pwm_s pwm_d, pwm_q;
    logic start;

    always_comb begin
        pwm_d = pwm_q;
        // limit seen in this period keeps the pulse from starting until the period wraps
        pwm_d.blk = !wrap_i && (pwm_q.blk || ilim_i);
        start     = (cnt_i < mag_i) && !pwm_q.blk && !ilim_i;
        pwm_d.pwm = en_i && falling_i && (pwm_q.pwm || start);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pwm_q <= '0;
        else         pwm_q <= pwm_d;
    end

    assign pwm_o = pwm_q.pwm;

endmodule

// File: rtl/qsteer_route.sv
module qsteer_route
    import qsteer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         ref_neg_i,
    input  logic         err_neg_i,
    input  logic [W-1:0] mag_i,
    input  logic         peak_i,
    input  logic         rise_body_i,
    input  logic         pwm_i,
    output logic [1:0]   mode_o,
    output logic         gd1_o,
    output logic         gd2_n_o,
    output logic         gd3_o,
    output logic         rgood_o
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        qmode_e     mode;
        logic [2:0] rect;
        logic       rgood;
    } route_s;

    route_s rt_d, rt_q;
    logic [2:0] act;

    always_comb begin
        rt_d = rt_q;
        if (peak_i) rt_d.mode = decode_mode(ref_neg_i, err_neg_i);
        rt_d.rect  = (en_i && rise_body_i) ? rect_gate(rt_q.mode) : 3'b000;
        rt_d.rgood = (mag_i != '0) && (mag_i != TOP);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rt_q.mode  <= MODE_REV_POS;
            rt_q.rect  <= 3'b000;
            rt_q.rgood <= 1'b0;
        end else begin
            rt_q <= rt_d;
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_gate
        assign act[g] = (pwm_i && pulse_gate(rt_q.mode)[g]) || rt_q.rect[g];
    end

    assign mode_o  = rt_q.mode;
    assign gd1_o   = act[0];
    assign gd2_n_o = ~act[1];
    assign gd3_o   = act[2];
    assign rgood_o = rt_q.rgood;

endmodule

// File: rtl/qsteer_top.sv
module qsteer_top #(
    parameter int MAG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             ref_neg_i,
    input  logic             err_neg_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             ilim_i,
    output logic             gd1_o,
    output logic             gd2_n_o,
    output logic             gd3_o,
    output logic             rgood_o
);
    logic [MAG_W-1:0] cnt_w;
    logic falling_w, peak_w, wrap_w, rise_body_w, pwm_w;
    logic [1:0] mode_w;

    qsteer_ramp #(.W(MAG_W)) u_ramp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cnt_o       (cnt_w),
        .falling_o   (falling_w),
        .peak_o      (peak_w),
        .wrap_o      (wrap_w),
        .rise_body_o (rise_body_w)
    );

    qsteer_pwm #(.W(MAG_W)) u_pwm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .ilim_i    (ilim_i),
        .mag_i     (mag_i),
        .cnt_i     (cnt_w),
        .falling_i (falling_w),
        .wrap_i    (wrap_w),
        .pwm_o     (pwm_w)
    );

    qsteer_route #(.W(MAG_W)) u_route (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .ref_neg_i   (ref_neg_i),
        .err_neg_i   (err_neg_i),
        .mag_i       (mag_i),
        .peak_i      (peak_w),
        .rise_body_i (rise_body_w),
        .pwm_i       (pwm_w),
        .mode_o      (mode_w),
        .gd1_o       (gd1_o),
        .gd2_n_o     (gd2_n_o),
        .gd3_o       (gd3_o),
        .rgood_o     (rgood_o)
    );

endmodule

// File: rtl/qsteer_chk.sv
module qsteer_chk #(
    parameter int MAG_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             ilim_i,
    input logic [MAG_W-1:0] mag_i,
    input logic             gd1_o,
    input logic             gd2_n_o,
    input logic             gd3_o,
    input logic             rgood_o,
    input logic             pwm_i,
    input logic             falling_i,
    input logic             peak_i,
    input logic [1:0]       mode_i
);
    localparam logic [MAG_W-1:0] TOP = '1;

    // R8: at most one gate conducts
    assert_one_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({gd1_o, ~gd2_n_o, gd3_o}));

    // R8: dead clock after the primary pulse ends
    assert_dead_time_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(gd1_o) |-> (gd2_n_o && !gd3_o));

    // R10: enable low forces every gate off at the next update
    assert_enable_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!gd1_o && gd2_n_o && !gd3_o));

    // R11: a limit flag prevents the pulse from starting on that sample
    assert_limit_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ilim_i |=> !$rose(pwm_i));

    // R7: the pulse begins only on the falling half
    assert_start_falling_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwm_i) |-> $past(falling_i));

    // R2: the latched mode moves only at the ramp peak
    assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !peak_i |=> $stable(mode_i));

    // R12: range flag follows the sampled magnitude
    assert_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (rgood_o == (($past(mag_i) != '0) && ($past(mag_i) != TOP))));

endmodule

bind qsteer_top qsteer_chk #(.MAG_W(MAG_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ilim_i    (ilim_i),
    .mag_i     (mag_i),
    .gd1_o     (gd1_o),
    .gd2_n_o   (gd2_n_o),
    .gd3_o     (gd3_o),
    .rgood_o   (rgood_o),
    .pwm_i     (pwm_w),
    .falling_i (falling_w),
    .peak_i    (peak_w),
    .mode_i    (mode_w)
);

// File: tb/qsteer_top_tb_top.sv
module qsteer_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int TOPV = (1 << W) - 1;
    localparam int HALF = 1 << W;
    localparam int PER  = 2 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, ref_neg = 1'b0, err_neg = 1'b0, ilim = 1'b0;
    logic [W-1:0] mag = '0;
    logic gd1, gd2_n, gd3, rgood;

    always #(CLK_PERIOD/2) clk = ~clk;

    qsteer_top #(.MAG_W(W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ref_neg_i(ref_neg),
        .err_neg_i(err_neg), .mag_i(mag), .ilim_i(ilim),
        .gd1_o(gd1), .gd2_n_o(gd2_n), .gd3_o(gd3), .rgood_o(rgood)
    );

    typedef struct {
        logic  g1, g2n, g3, rg;
        string tag;
        int    per, pos;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0, n_bad = 0, per_idx = 0;
    int   mode_act = 2;      // R2: reset mode is mode 2
    bit   pulse = 0, blocked = 0, done = 0;

    function automatic int mode_num(bit rn, bit er);
        if (!rn) return er ? 2 : 1;
        return er ? 3 : 4;
    endfunction

    // driver: applies one ramp period of stimulus and queues the expected outputs
    task automatic run_period(bit rn, bit er, int m, int en_off, int ilim_pos, string tag);
        for (int pos = 0; pos < PER; pos++) begin
            exp_t it;
            bit en_now, il_now, down, pw, rp, rnx;
            int cnt;
            @(negedge clk);
            en_now = (pos < en_off);
            il_now = (pos == ilim_pos);
            en = en_now; ilim = il_now; ref_neg = rn; err_neg = er; mag = m[W-1:0];
            down = (pos >= HALF);
            cnt  = down ? (PER - 1 - pos) : pos;
            if (pos == 0) blocked = 0;
            pw = 0; rp = 0; rnx = 0;
            if (down) pw = en_now && (pulse || (cnt < m && !blocked && !il_now));
            else if (en_now && pos != 0) begin
                rp  = (mode_act == 1);
                rnx = (mode_act == 3);
            end
            if (il_now) blocked = 1;
            pulse  = pw;
            it.g1  = pw && (mode_act == 1 || mode_act == 3);
            it.g3  = (pw && mode_act == 2) || rnx;
            it.g2n = !((pw && mode_act == 4) || rp);
            it.rg  = (m != 0) && (m != TOPV);
            it.tag = tag; it.per = per_idx; it.pos = pos;
            sbq.push_back(it);
            if (pos == HALF - 1) mode_act = mode_num(rn, er);
        end
        per_idx++;
    endtask

    // monitor: compares after each edge, away from it
    always @(posedge clk) begin
        exp_t it;
        #1;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            n_cmp++;
            if ({gd1, gd2_n, gd3, rgood} !== {it.g1, it.g2n, it.g3, it.rg}) begin
                n_bad++;
                $display("FAIL %s period %0d pos %0d: got gd1=%b gd2_n=%b gd3=%b rgood=%b expected %b %b %b %b",
                         it.tag, it.per, it.pos, gd1, gd2_n, gd3, rgood, it.g1, it.g2n, it.g3, it.rg);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        en = 1'b1; mag = 8'd100;
        repeat (3) @(negedge clk);
        // R1: reset state, even with enable and a valid magnitude present
        n_cmp++;
        if ({gd1, gd2_n, gd3, rgood} !== 4'b0100) begin
            n_bad++;
            $display("FAIL R1 reset: got %b%b%b%b expected 0100", gd1, gd2_n, gd3, rgood);
        end
        @(posedge clk); #2; rst_n = 1'b1;

        run_period(0, 0, 100, PER, -1, "R1/R2/R3/R7");  // up half uses reset mode 2
        run_period(0, 0, 255, PER, -1, "R3/R8/R12");    // mode 1 rectifier, full-scale magnitude
        run_period(0, 1, 40,  PER, -1, "R4/R8");        // mode 2 pulse on gd3
        run_period(1, 1, 0,   PER, -1, "R5/R7/R12");    // zero magnitude: no pulse
        run_period(1, 1, 200, PER, -1, "R5/R8");        // mode 3, gd3 rectifies
        run_period(1, 0, 77,  PER, -1, "R6/R9");        // mode 4, pulse on active-low gd2
        run_period(0, 0, 120, PER, 300, "R11 before start");
        run_period(0, 0, 120, PER, 392, "R11 same cycle as start");
        run_period(0, 0, 120, PER, 450, "R11 after start");
        run_period(0, 0, 120, PER, -1, "R11 next period");
        run_period(0, 0, 120, 420, -1, "R10 mid-pulse");
        run_period(1, 1, 200, 0,   -1, "R10 whole period");
        run_period(0, 1, 1,   PER, -1, "R7/R12 single clock");
        run_period(1, 0, 254, PER, -1, "R6/R12 widest");

        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule